// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between an in-order core and a data-cache write port. The core records each store in program order as it is issued. The store's address and its data arrive later, each on its own fill port, and each fill names the slot it belongs to. Stores leave the buffer in allocation order through a single cache write port. Each write that is accepted opens an acknowledgement that the memory side closes later, once the invalidations for it have completed.

The core presents each load to the buffer. The load is compared with every buffered store, and all of those stores are older than the load. If none of them can touch the load's address, the load goes to the cache at once, ahead of the stores. If the youngest store with a matching address already holds its data, that data is returned and the cache is not read. In every other case the load waits and is retried on the next cycle.

A full fence holds back all later loads and stores until the buffer is empty and no acknowledgement is outstanding. A store marked as a release cannot leave the buffer until every earlier write has been acknowledged. A load marked as an acquire blocks new stores for as long as it waits.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` and `fence_done` are 1, `cw_valid` is 0 and `alloc_idx` is 0.
- R2: An allocation is accepted in a cycle where `alloc_valid` and `alloc_ready` are both high. It takes slot `alloc_idx`, which starts at 0 and steps by one modulo 8 for each accepted store. When all 8 slots are occupied, `alloc_ready` is low.
- R3: A load that is not stalled and has no buffered store with a matching address raises `rd_valid` in the same cycle, with `rd_addr` equal to `ld_addr`, and `ld_fwd_valid` stays low.
- R4: A load that is not stalled and has a matching buffered store raises `ld_fwd_valid` with the data of the youngest matching store, and `rd_valid` stays low.
- R5: A presented load raises `ld_stall`, and neither of its result outputs, when any buffered store still lacks its address, when the youngest matching store still lacks its data, or when a fence is blocking.
- R6: `cw_valid` is high only when the oldest buffered store knows both its address and its data, and fewer than 15 acknowledgements are outstanding. `cw_addr` and `cw_data` carry that store's fields. Stores leave in allocation order, one per cycle in which `cw_ready` is high.
- R7: A store allocated with `alloc_rel` = 1 raises `cw_valid` only when no acknowledgement is outstanding.
- R8: `fence_done` is high exactly when the buffer is empty and no acknowledgement is outstanding. While `fence_req` is high and `fence_done` is low, `alloc_ready` is low and any presented load stalls.
- R9: While a load with `ld_acq` = 1 is stalled, `alloc_ready` is low.
- R10: A fill to a slot that is not occupied, or to a field that already holds a value, has no effect.
- R11: Outstanding acknowledgements go up by one for each accepted cache write and down by one for each cycle in which `cw_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Core issues a store |
| alloc_rel | input | 1 | The issued store is a release |
| alloc_ready | output | 1 | The store can be accepted this cycle |
| alloc_idx | output | 3 | Slot the next store will take |
| afill_valid | input | 1 | An address is delivered |
| afill_idx | input | 3 | Slot that receives the address |
| afill_addr | input | 16 | Store address |
| dfill_valid | input | 1 | Data is delivered |
| dfill_idx | input | 3 | Slot that receives the data |
| dfill_data | input | 32 | Store data |
| ld_valid | input | 1 | A load is presented |
| ld_acq | input | 1 | The load is an acquire |
| ld_addr | input | 16 | Load address |
| ld_stall | output | 1 | The load must be retried |
| ld_fwd_valid | output | 1 | The load is served from the buffer |
| ld_fwd_data | output | 32 | Forwarded data |
| rd_valid | output | 1 | The load is sent to the cache |
| rd_addr | output | 16 | Cache read address |
| fence_req | input | 1 | Full fence is pending |
| fence_done | output | 1 | The fence may complete |
| cw_valid | output | 1 | A cache write is offered |
| cw_addr | output | 16 | Write address |
| cw_data | output | 32 | Write data |
| cw_ready | input | 1 | The cache accepts the write |
| cw_ack | input | 1 | One invalidation acknowledgement returns |

## Verification
The bench goes after loads that match several stores. A design that picks the oldest matching store, or that ignores a store whose address is still unknown, returns stale data. It also targets a match whose data is missing: a design that gets this wrong forwards garbage or sends the load to the cache. A release sits behind unacknowledged writes, and a design that drains it early exposes the release before the writes ahead of it are visible. A fence raised while acknowledgements are still open shows whether a design signals `fence_done` as soon as the buffer is empty. Random traffic on four addresses also sends fills to free slots and repeated fills, which catches a design that overwrites a known field or revives a slot that has already drained.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_WAIT = 2'd1,
        LD_FWD  = 2'd2,
        LD_MISS = 2'd3
    } ld_kind_e;
endpackage

// File: rtl/sb_resolve.sv
module sb_resolve
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic [DEPTH-1:0]         aok,
    input  logic [DEPTH-1:0]         dok,
    input  logic [DEPTH-1:0][AW-1:0] addr,
    input  logic [DEPTH-1:0][DW-1:0] data,
    input  logic [IW-1:0]            head,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic                     block,
    output ld_kind_e                 kind,
    output logic [DW-1:0]            fwd_data
);
    logic          any_unk;
    logic          hit;
    logic          hit_dok;
    logic [IW-1:0] idx;

    // Walk oldest to youngest so that the youngest match is the one kept.
    always_comb begin
        any_unk  = 1'b0;
        hit      = 1'b0;
        hit_dok  = 1'b0;
        fwd_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IW'(k);
            if (vld[idx]) begin
                if (!aok[idx]) begin
                    any_unk = 1'b1;
                end else if (addr[idx] == ld_addr) begin
                    hit      = 1'b1;
                    hit_dok  = dok[idx];
                    fwd_data = data[idx];
                end
            end
        end
        if (!ld_valid)                            kind = LD_NONE;
        else if (block || any_unk || (hit && !hit_dok)) kind = LD_WAIT;
        else if (hit)                             kind = LD_FWD;
        else                                      kind = LD_MISS;
    end
endmodule

// File: rtl/sb_ack_tracker.sv
module sb_ack_tracker #(
    parameter int MAX_OUT = 15,
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic ack,
    output logic zero,
    output logic at_max
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue && !ack)      cnt_d = cnt_q + 1'b1;
        else if (!issue && ack) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero   = (cnt_q == '0);
    assign at_max = (cnt_q == CW'(MAX_OUT));
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int MAX_OUT = 15,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_rel,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    input  logic          afill_valid,
    input  logic [IW-1:0] afill_idx,
    input  logic [AW-1:0] afill_addr,
    input  logic          dfill_valid,
    input  logic [IW-1:0] dfill_idx,
    input  logic [DW-1:0] dfill_data,
    input  logic          ld_valid,
    input  logic          ld_acq,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_stall,
    output logic          ld_fwd_valid,
    output logic [DW-1:0] ld_fwd_data,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          fence_req,
    output logic          fence_done,
    output logic          cw_valid,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    input  logic          cw_ready,
    input  logic          cw_ack
);
    typedef struct packed {
        logic          vld;
        logic          aok;
        logic          dok;
        logic          rel;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [IW-1:0]    head;
        logic [IW-1:0]    tail;
        logic [IW:0]      cnt;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]         v_vld, v_aok, v_dok;
    logic [DEPTH-1:0][AW-1:0] v_addr;
    logic [DEPTH-1:0][DW-1:0] v_data;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign v_vld[i]  = st_q.ent[i].vld;
        assign v_aok[i]  = st_q.ent[i].aok;
        assign v_dok[i]  = st_q.ent[i].dok;
        assign v_addr[i] = st_q.ent[i].addr;
        assign v_data[i] = st_q.ent[i].data;
    end

    logic     full, empty, fence_block, ack_zero, ack_max, hd_rel, push, pop;
    ent_t     hd;
    ld_kind_e kind;

    assign full        = (st_q.cnt == (IW+1)'(DEPTH));
    assign empty       = (st_q.cnt == '0);
    assign hd          = st_q.ent[st_q.head];
    assign hd_rel      = hd.vld && hd.rel;
    assign fence_done  = empty && ack_zero;
    assign fence_block = fence_req && !fence_done;

    sb_resolve #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_resolve (
        .vld      (v_vld),
        .aok      (v_aok),
        .dok      (v_dok),
        .addr     (v_addr),
        .data     (v_data),
        .head     (st_q.head),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .block    (fence_block),
        .kind     (kind),
        .fwd_data (ld_fwd_data)
    );

    assign ld_stall     = (kind == LD_WAIT);
    assign ld_fwd_valid = (kind == LD_FWD);
    assign rd_valid     = (kind == LD_MISS);
    assign rd_addr      = ld_addr;

    assign alloc_ready = !full && !fence_block && !(ld_acq && ld_stall);
    assign alloc_idx   = st_q.tail;

    assign cw_valid = hd.vld && hd.aok && hd.dok && (!hd.rel || ack_zero) && !ack_max;
    assign cw_addr  = hd.addr;
    assign cw_data  = hd.data;

    assign push = alloc_valid && alloc_ready;
    assign pop  = cw_valid && cw_ready;

    sb_ack_tracker #(.MAX_OUT(MAX_OUT)) u_acks (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (pop),
        .ack    (cw_ack),
        .zero   (ack_zero),
        .at_max (ack_max)
    );

    always_comb begin
        st_d = st_q;
        if (afill_valid && st_q.ent[afill_idx].vld && !st_q.ent[afill_idx].aok) begin
            st_d.ent[afill_idx].aok  = 1'b1;
            st_d.ent[afill_idx].addr = afill_addr;
        end
        if (dfill_valid && st_q.ent[dfill_idx].vld && !st_q.ent[dfill_idx].dok) begin
            st_d.ent[dfill_idx].dok  = 1'b1;
            st_d.ent[dfill_idx].data = dfill_data;
        end
        if (pop) begin
            st_d.ent[st_q.head].vld = 1'b0;
            st_d.head               = st_q.head + 1'b1;
        end
        if (push) begin
            st_d.ent[st_q.tail] = '{vld: 1'b1, aok: 1'b0, dok: 1'b0, rel: alloc_rel,
                                   addr: '0, data: '0};
            st_d.tail           = st_q.tail + 1'b1;
        end
        st_d.cnt = st_q.cnt + (IW+1)'(push) - (IW+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full,
    input logic          alloc_ready,
    input logic          ld_valid,
    input logic          ld_acq,
    input logic          ld_stall,
    input logic          ld_fwd_valid,
    input logic          rd_valid,
    input logic          fence_req,
    input logic          fence_done,
    input logic          cw_valid,
    input logic          cw_ready,
    input logic [AW-1:0] cw_addr,
    input logic [DW-1:0] cw_data,
    input logic          head_rel,
    input logic          ack_zero
);
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);

    p_one_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_fwd_valid && rd_valid));

    p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> (ld_valid && !ld_fwd_valid && !rd_valid));

    p_cw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data)));

    p_rel_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && head_rel) |-> ack_zero);

    p_fence_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && !fence_done) |-> (!alloc_ready && !ld_fwd_valid && !rd_valid));

    p_fence_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (!cw_valid && ack_zero));

    p_acq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_acq && ld_stall) |-> !alloc_ready);
endmodule

bind store_buffer sb_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .full         (full),
    .alloc_ready  (alloc_ready),
    .ld_valid     (ld_valid),
    .ld_acq       (ld_acq),
    .ld_stall     (ld_stall),
    .ld_fwd_valid (ld_fwd_valid),
    .rd_valid     (rd_valid),
    .fence_req    (fence_req),
    .fence_done   (fence_done),
    .cw_valid     (cw_valid),
    .cw_ready     (cw_ready),
    .cw_addr      (cw_addr),
    .cw_data      (cw_data),
    .head_rel     (hd_rel),
    .ack_zero     (ack_zero)
);

// File: tb/store_buffer_bench.sv
`timescale 1ns/1ps
module store_buffer_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int MAXO  = 15;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          alloc_valid, alloc_rel, alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic          afill_valid, dfill_valid;
    logic [IW-1:0] afill_idx, dfill_idx;
    logic [AW-1:0] afill_addr, ld_addr, rd_addr, cw_addr;
    logic [DW-1:0] dfill_data, ld_fwd_data, cw_data;
    logic          ld_valid, ld_acq, ld_stall, ld_fwd_valid, rd_valid;
    logic          fence_req, fence_done, cw_valid, cw_ready, cw_ack;

    store_buffer u_store_buffer (.*);

    typedef struct {
        int          idx;
        bit          aok;
        bit [AW-1:0] addr;
        bit          dok;
        bit [DW-1:0] data;
        bit          rel;
    } me_t;

    me_t q[$];
    int  acks = 0;
    int  tail = 0;
    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_rel = 0;
        afill_valid = 0; afill_idx = '0; afill_addr = '0;
        dfill_valid = 0; dfill_idx = '0; dfill_data = '0;
        ld_valid = 0; ld_acq = 0; ld_addr = '0;
        fence_req = 0; cw_ready = 0; cw_ack = 0;
    endtask

    // One cycle: compare outputs with the model, then advance the model at the edge.
    task automatic step();
        bit fdone, fblk, any_unk, hit, hdok, e_stall, e_fwd, e_rd, e_ar, e_cw;
        bit [DW-1:0] hdata;
        #1;
        fdone = (q.size() == 0) && (acks == 0);
        fblk  = fence_req && !fdone;
        any_unk = 0; hit = 0; hdok = 0; hdata = '0;
        foreach (q[i]) begin
            if (!q[i].aok) any_unk = 1;
            else if (q[i].addr == ld_addr) begin hit = 1; hdok = q[i].dok; hdata = q[i].data; end
        end
        e_stall = ld_valid && (fblk || any_unk || (hit && !hdok));
        e_fwd   = ld_valid && !e_stall && hit;
        e_rd    = ld_valid && !e_stall && !hit;
        e_ar    = (q.size() < DEPTH) && !fblk && !(ld_acq && e_stall);
        e_cw    = (q.size() > 0) && q[0].aok && q[0].dok && (!q[0].rel || acks == 0) && (acks < MAXO);

        chk(alloc_ready == e_ar, "R2 R8 R9 alloc_ready", alloc_ready, e_ar);
        chk(alloc_idx == IW'(tail), "R2 alloc_idx", alloc_idx, tail);
        chk(ld_stall == e_stall, "R5 ld_stall", ld_stall, e_stall);
        chk(ld_fwd_valid == e_fwd, "R4 ld_fwd_valid", ld_fwd_valid, e_fwd);
        if (e_fwd) chk(ld_fwd_data == hdata, "R4 ld_fwd_data", ld_fwd_data, hdata);
        chk(rd_valid == e_rd, "R3 rd_valid", rd_valid, e_rd);
        if (e_rd) chk(rd_addr == ld_addr, "R3 rd_addr", rd_addr, ld_addr);
        chk(fence_done == fdone, "R8 R11 fence_done", fence_done, fdone);
        chk(cw_valid == e_cw, "R6 R7 R11 cw_valid", cw_valid, e_cw);
        if (e_cw) begin
            chk(cw_addr == q[0].addr, "R6 cw_addr", cw_addr, q[0].addr);
            chk(cw_data == q[0].data, "R6 cw_data", cw_data, q[0].data);
        end

        @(posedge clk);
        foreach (q[i]) begin
            me_t e;
            e = q[i];
            if (afill_valid && e.idx == int'(afill_idx) && !e.aok) begin e.aok = 1; e.addr = afill_addr; end
            if (dfill_valid && e.idx == int'(dfill_idx) && !e.dok) begin e.dok = 1; e.data = dfill_data; end
            q[i] = e;
        end
        if (e_cw && cw_ready) begin void'(q.pop_front()); acks++; end
        if (cw_ack) acks--;
        if (alloc_valid && e_ar) begin
            me_t n;
            n.idx = tail; n.aok = 0; n.addr = '0; n.dok = 0; n.data = '0; n.rel = alloc_rel;
            q.push_back(n);
            tail = (tail + 1) % DEPTH;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(alloc_ready === 1'b1, "R1 alloc_ready", alloc_ready, 1);
        chk(fence_done === 1'b1, "R1 fence_done", fence_done, 1);
        chk(cw_valid === 1'b0, "R1 cw_valid", cw_valid, 0);
        chk(alloc_idx === '0, "R1 alloc_idx", alloc_idx, 0);
        @(negedge clk);

        // Three stores, nothing drains yet.
        for (int i = 0; i < 3; i++) begin idle(); alloc_valid = 1; step(); end
        idle(); ld_valid = 1; ld_addr = 16'h0010; step();          // R5 unknown address
        idle(); afill_valid = 1; afill_idx = 0; afill_addr = 16'h0010;
        dfill_valid = 1; dfill_idx = 0; dfill_data = 32'hAAAA0000; step();
        idle(); afill_valid = 1; afill_idx = 1; afill_addr = 16'h0014; step();
        idle(); afill_valid = 1; afill_idx = 2; afill_addr = 16'h0010;
        dfill_valid = 1; dfill_idx = 2; dfill_data = 32'hBBBB2222; step();
        // R10: refill of known field and fill of free slot
        idle(); afill_valid = 1; afill_idx = 0; afill_addr = 16'h0099;
        dfill_valid = 1; dfill_idx = 5; dfill_data = 32'h55; step();
        idle(); ld_valid = 1; ld_addr = 16'h0010; step();          // R4 youngest match
        idle(); ld_valid = 1; ld_addr = 16'h0099; step();          // R3 miss, R10
        idle(); ld_valid = 1; ld_addr = 16'h0014; step();          // R5 data unknown
        idle(); ld_valid = 1; ld_acq = 1; ld_addr = 16'h0014; alloc_valid = 1; step(); // R9
        idle(); dfill_valid = 1; dfill_idx = 1; dfill_data = 32'h11111111; step();
        for (int i = 0; i < 3; i++) begin idle(); cw_ready = 1; step(); end  // R6 drain
        // Release store behind three open acknowledgements: R7
        idle(); alloc_valid = 1; alloc_rel = 1; step();
        idle(); afill_valid = 1; afill_idx = 3; afill_addr = 16'h0018;
        dfill_valid = 1; dfill_idx = 3; dfill_data = 32'hCCCC; step();
        idle(); cw_ready = 1; fence_req = 1; ld_valid = 1; ld_addr = 16'h0040; alloc_valid = 1; step(); // R8
        for (int i = 0; i < 3; i++) begin idle(); cw_ready = 1; fence_req = 1; cw_ack = 1; step(); end
        idle(); cw_ready = 1; fence_req = 1; step();
        idle(); fence_req = 1; cw_ack = 1; step();
        idle(); fence_req = 1; step();                               // R8 done
        // Fill the buffer: R2
        for (int i = 0; i < DEPTH + 1; i++) begin idle(); alloc_valid = 1; step(); end
        idle(); ld_valid = 1; ld_addr = 16'h0010; step();

        // Random traffic on four addresses.
        begin
            bit fhold;
            fhold = 0;
            for (int c = 0; c < 4000; c++) begin
                idle();
                alloc_valid = ($urandom % 3) == 0;
                alloc_rel   = ($urandom % 5) == 0;
                if (($urandom % 2) == 0) begin
                    afill_valid = 1;
                    afill_idx   = (q.size() > 0 && ($urandom % 4) != 0) ? IW'(q[$urandom % q.size()].idx) : IW'($urandom);
                    afill_addr  = 16'h0010 + AW'(4 * ($urandom % 4));
                end
                if (($urandom % 2) == 0) begin
                    dfill_valid = 1;
                    dfill_idx   = (q.size() > 0 && ($urandom % 4) != 0) ? IW'(q[$urandom % q.size()].idx) : IW'($urandom);
                    dfill_data  = $urandom;
                end
                ld_valid = ($urandom % 2) == 0;
                ld_acq   = ($urandom % 5) == 0;
                ld_addr  = 16'h0010 + AW'(4 * ($urandom % 4));
                if (!fhold && ($urandom % 40) == 0) fhold = 1;
                else if (fhold && q.size() == 0 && acks == 0) fhold = 0;
                fence_req = fhold;
                cw_ready  = ($urandom % 10) < 7;
                cw_ack    = (acks > 0) && (($urandom % 10) < 4);
                step();
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule